// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, one destination address at a time, whether a received frame is kept or dropped. The caller presents the six destination bytes with a valid strobe. One clock later the block returns a valid pulse and an accept flag. Three control inputs can accept frames outright: unicast promiscuous, multicast promiscuous and broadcast accept. If none of them applies, the address is compared against two tables. The first is an exact-match table of 16 entries, each with its own valid bit. The second is a 4096-bit multicast hash table, indexed by a shifted window over the last two destination bytes.

Software-side logic loads both tables through two plain word-write ports. These are kept in registers inside the block. The exact table takes one 32-bit word per write, either the low or the high half of an entry. The hash table takes one 32-bit word of its 128 words per write. A write that lands in the same cycle as a lookup does not affect that lookup. It is seen by the next one.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, decisionValid and decisionAccept are 0, every exact entry is invalid and every hash bit is 0, so a lookup with all controls off is rejected.
- R2: A lookup strobed in cycle N gives decisionValid high in cycle N+1 only. Back-to-back lookups give back-to-back decisions, each for its own address.
- R3: When cfgUniPromisc is 1, every lookup is accepted.
- R4: When cfgMultiPromisc is 1, a lookup whose byte 0 (lookupAddr[7:0]) has bit 0 set is accepted. A set bit 0 in any other byte does not count.
- R5: When cfgBcastEn is 1, an address of all 0xFF bytes is accepted. The same address is not accepted by this rule when cfgBcastEn is 0.
- R6: An exact entry matches when its high word bit 31 is set and lookupAddr equals {high[15:0], low[31:0]}, so byte 0 sits in low[7:0] and byte 5 sits in high[15:8]. Entries 0 and 15 both take part.
- R7: An entry whose high word bit 31 is 0 never matches, whatever its address bits hold.
- R8: The hash index is lookupAddr[47:32] shifted right by 4, 3, 2 or 0 for cfgHashMode 0, 1, 2 or 3, then kept to its low 12 bits.
- R9: Hash index bits [11:5] select one of 128 hash words and bits [4:0] select a bit in that word. Only a set bit at exactly that position accepts the frame.
- R10: An address that meets none of the rules above is rejected.
- R11: A table write made in the same cycle as a lookup does not change that lookup's result and does change the next lookup's result.
- R12: decisionAccept is 0 whenever decisionValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgUniPromisc | input | 1 | Accept every address |
| cfgMultiPromisc | input | 1 | Accept every group address (byte 0 bit 0 set) |
| cfgBcastEn | input | 1 | Accept the all-ones address |
| cfgHashMode | input | 2 | Selects the hash window shift (4, 3, 2, 0) |
| lookupValid | input | 1 | Lookup strobe |
| lookupAddr | input | 48 | Destination address, byte 0 in bits [7:0] |
| exactWrEn | input | 1 | Exact table word write strobe |
| exactWrIdx | input | 4 | Exact entry to write |
| exactWrHigh | input | 1 | 1 writes the high word, 0 writes the low word |
| exactWrData | input | 32 | Exact table write data |
| hashWrEn | input | 1 | Hash table word write strobe |
| hashWrIdx | input | 7 | Hash word to write |
| hashWrData | input | 32 | Hash word write data |
| decisionValid | output | 1 | Decision strobe, one cycle after lookupValid |
| decisionAccept | output | 1 | 1 means the frame is accepted, qualified by decisionValid |

## Verification
The assertions check on every cycle the parts of the behaviour that the ports alone decide. These are the one-cycle strobe timing, the qualification of the accept flag, and the three control overrides (unicast promiscuous, group bit with multicast promiscuous, all-ones with broadcast accept). Anything that depends on table contents can only be shown by the bench scenarios. That covers the byte order of exact entries, the effect of the per-entry valid bit, the hash index for each shift mode with its word and bit selection, and the ordering of a table write against a lookup in the same cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W     = 48;
  localparam int HASH_SRC_W = 16;
  localparam int MODE_W     = 2;

  typedef struct packed {
    logic lookup;
    logic wrExactLo;
    logic wrExactHi;
    logic wrHash;
  } rxfStrobes_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lookupValid,
  input  logic                 exactWrEn,
  input  logic                 exactWrHigh,
  input  logic                 hashWrEn,
  output rxf_pkg::rxfStrobes_t strobes,
  output logic                 decisionValid
);
  always_comb begin
    strobes.lookup    = lookupValid;
    strobes.wrExactLo = exactWrEn && !exactWrHigh;
    strobes.wrExactHi = exactWrEn && exactWrHigh;
    strobes.wrHash    = hashWrEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) decisionValid <= 1'b0;
    else        decisionValid <= lookupValid;
  end
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath #(
  parameter int EXACT_ENTRIES = 16,
  parameter int HASH_WORDS    = 128,
  parameter int WORD_W        = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  rxf_pkg::rxfStrobes_t             strobes,
  input  logic                             cfgUniPromisc,
  input  logic                             cfgMultiPromisc,
  input  logic                             cfgBcastEn,
  input  logic [rxf_pkg::MODE_W-1:0]       cfgHashMode,
  input  logic [rxf_pkg::ADDR_W-1:0]       lookupAddr,
  input  logic [$clog2(EXACT_ENTRIES)-1:0] exactWrIdx,
  input  logic [WORD_W-1:0]                exactWrData,
  input  logic [$clog2(HASH_WORDS)-1:0]    hashWrIdx,
  input  logic [WORD_W-1:0]                hashWrData,
  output logic                             decisionAccept
);
  localparam int HI_ADDR_W  = rxf_pkg::ADDR_W - WORD_W;
  localparam int VALID_BIT  = WORD_W - 1;
  localparam int BIT_SEL_W  = $clog2(WORD_W);
  localparam int WORD_SEL_W = $clog2(HASH_WORDS);
  localparam int HASH_IDX_W = WORD_SEL_W + BIT_SEL_W;
  localparam int SHIFT_M0   = 4;
  localparam int SHIFT_M1   = 3;
  localparam int SHIFT_M2   = 2;
  localparam int SHIFT_M3   = 0;

  logic [WORD_W-1:0]    exactLo   [EXACT_ENTRIES];
  logic [HI_ADDR_W-1:0] exactHi   [EXACT_ENTRIES];
  logic [EXACT_ENTRIES-1:0] entryValid;
  logic [WORD_W-1:0]    hashMem   [HASH_WORDS];

  // Table storage: a same-cycle lookup reads the pre-write contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entryValid <= '0;
      for (int i = 0; i < EXACT_ENTRIES; i++) begin
        exactLo[i] <= '0;
        exactHi[i] <= '0;
      end
      for (int j = 0; j < HASH_WORDS; j++) hashMem[j] <= '0;
    end else begin
      if (strobes.wrExactLo) exactLo[exactWrIdx] <= exactWrData;
      if (strobes.wrExactHi) begin
        exactHi[exactWrIdx]    <= exactWrData[HI_ADDR_W-1:0];
        entryValid[exactWrIdx] <= exactWrData[VALID_BIT];
      end
      if (strobes.wrHash) hashMem[hashWrIdx] <= hashWrData;
    end
  end

  // Exact-match comparators, one per entry.
  logic [EXACT_ENTRIES-1:0] entryHit;
  for (genvar e = 0; e < EXACT_ENTRIES; e++) begin : g_exact
    assign entryHit[e] = entryValid[e] &&
                         (lookupAddr == {exactHi[e], exactLo[e]});
  end

  // Hash index from the last two address bytes.
  logic [rxf_pkg::HASH_SRC_W-1:0] hashSrc;
  logic [HASH_IDX_W-1:0]          hashIdx;
  logic [WORD_SEL_W-1:0]          hashWordSel;
  logic [BIT_SEL_W-1:0]           hashBitSel;
  logic [WORD_W-1:0]              hashWord;
  logic                           hashHit;

  assign hashSrc = lookupAddr[rxf_pkg::ADDR_W-1 -: rxf_pkg::HASH_SRC_W];

  always_comb begin
    unique case (cfgHashMode)
      2'd0:    hashIdx = hashSrc[HASH_IDX_W-1+SHIFT_M0:SHIFT_M0];
      2'd1:    hashIdx = hashSrc[HASH_IDX_W-1+SHIFT_M1:SHIFT_M1];
      2'd2:    hashIdx = hashSrc[HASH_IDX_W-1+SHIFT_M2:SHIFT_M2];
      default: hashIdx = hashSrc[HASH_IDX_W-1+SHIFT_M3:SHIFT_M3];
    endcase
  end

  assign hashWordSel = hashIdx[HASH_IDX_W-1:BIT_SEL_W];
  assign hashBitSel  = hashIdx[BIT_SEL_W-1:0];
  assign hashWord    = hashMem[hashWordSel];
  assign hashHit     = hashWord[hashBitSel];

  logic bcastHit;
  logic groupBit;
  logic acceptNext;
  assign bcastHit   = &lookupAddr;
  assign groupBit   = lookupAddr[0];
  assign acceptNext = cfgUniPromisc
                    | (cfgMultiPromisc & groupBit)
                    | (cfgBcastEn & bcastHit)
                    | (|entryHit)
                    | hashHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) decisionAccept <= 1'b0;
    else        decisionAccept <= strobes.lookup & acceptNext;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int EXACT_ENTRIES = 16,
  parameter int HASH_WORDS    = 128,
  parameter int WORD_W        = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfgUniPromisc,
  input  logic                             cfgMultiPromisc,
  input  logic                             cfgBcastEn,
  input  logic [rxf_pkg::MODE_W-1:0]       cfgHashMode,
  input  logic                             lookupValid,
  input  logic [rxf_pkg::ADDR_W-1:0]       lookupAddr,
  input  logic                             exactWrEn,
  input  logic [$clog2(EXACT_ENTRIES)-1:0] exactWrIdx,
  input  logic                             exactWrHigh,
  input  logic [WORD_W-1:0]                exactWrData,
  input  logic                             hashWrEn,
  input  logic [$clog2(HASH_WORDS)-1:0]    hashWrIdx,
  input  logic [WORD_W-1:0]                hashWrData,
  output logic                             decisionValid,
  output logic                             decisionAccept
);
  rxf_pkg::rxfStrobes_t strobes;

  rxf_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .lookupValid   (lookupValid),
    .exactWrEn     (exactWrEn),
    .exactWrHigh   (exactWrHigh),
    .hashWrEn      (hashWrEn),
    .strobes       (strobes),
    .decisionValid (decisionValid)
  );

  rxf_datapath #(
    .EXACT_ENTRIES (EXACT_ENTRIES),
    .HASH_WORDS    (HASH_WORDS),
    .WORD_W        (WORD_W)
  ) u_dp (
    .clk             (clk),
    .rst_n           (rst_n),
    .strobes         (strobes),
    .cfgUniPromisc   (cfgUniPromisc),
    .cfgMultiPromisc (cfgMultiPromisc),
    .cfgBcastEn      (cfgBcastEn),
    .cfgHashMode     (cfgHashMode),
    .lookupAddr      (lookupAddr),
    .exactWrIdx      (exactWrIdx),
    .exactWrData     (exactWrData),
    .hashWrIdx       (hashWrIdx),
    .hashWrData      (hashWrData),
    .decisionAccept  (decisionAccept)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfgUniPromisc,
  input logic        cfgMultiPromisc,
  input logic        cfgBcastEn,
  input logic        lookupValid,
  input logic [47:0] lookupAddr,
  input logic        decisionValid,
  input logic        decisionAccept
);
  // R2: strobe appears exactly one cycle after a lookup
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> decisionValid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |=> !decisionValid);

  // R12: accept flag is qualified by the strobe
  a_r12_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !decisionValid |-> !decisionAccept);

  // R3: unicast promiscuous accepts everything
  a_r3_uni_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && cfgUniPromisc) |=> decisionAccept);

  // R4: group bit with multicast promiscuous
  a_r4_multi_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && cfgMultiPromisc && lookupAddr[0]) |=> decisionAccept);

  // R5: all-ones address with broadcast accept
  a_r5_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && cfgBcastEn && (&lookupAddr)) |=> decisionAccept);
endmodule

bind rx_addr_filter rxf_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfgUniPromisc  (cfgUniPromisc),
  .cfgMultiPromisc(cfgMultiPromisc),
  .cfgBcastEn     (cfgBcastEn),
  .lookupValid    (lookupValid),
  .lookupAddr     (lookupAddr),
  .decisionValid  (decisionValid),
  .decisionAccept (decisionAccept)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgUniPromisc = 1'b0;
  logic        cfgMultiPromisc = 1'b0;
  logic        cfgBcastEn = 1'b0;
  logic [1:0]  cfgHashMode = 2'd0;
  logic        lookupValid = 1'b0;
  logic [47:0] lookupAddr = '0;
  logic        exactWrEn = 1'b0;
  logic [3:0]  exactWrIdx = '0;
  logic        exactWrHigh = 1'b0;
  logic [31:0] exactWrData = '0;
  logic        hashWrEn = 1'b0;
  logic [6:0]  hashWrIdx = '0;
  logic [31:0] hashWrData = '0;
  logic        decisionValid;
  logic        decisionAccept;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n),
    .cfgUniPromisc(cfgUniPromisc), .cfgMultiPromisc(cfgMultiPromisc),
    .cfgBcastEn(cfgBcastEn), .cfgHashMode(cfgHashMode),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .exactWrEn(exactWrEn), .exactWrIdx(exactWrIdx),
    .exactWrHigh(exactWrHigh), .exactWrData(exactWrData),
    .hashWrEn(hashWrEn), .hashWrIdx(hashWrIdx), .hashWrData(hashWrData),
    .decisionValid(decisionValid), .decisionAccept(decisionAccept)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic writeExact(input logic [3:0] idx, input logic [31:0] lo,
                            input logic [31:0] hi);
    @(negedge clk);
    exactWrEn = 1'b1; exactWrIdx = idx; exactWrHigh = 1'b0; exactWrData = lo;
    @(negedge clk);
    exactWrHigh = 1'b1; exactWrData = hi;
    @(negedge clk);
    exactWrEn = 1'b0; exactWrHigh = 1'b0;
  endtask

  task automatic writeHash(input logic [6:0] idx, input logic [31:0] data);
    @(negedge clk);
    hashWrEn = 1'b1; hashWrIdx = idx; hashWrData = data;
    @(negedge clk);
    hashWrEn = 1'b0;
  endtask

  // One lookup: strobe, decision one cycle later, strobe gone after that.
  task automatic runLookup(input string req, input logic [47:0] a,
                           input logic exp);
    @(negedge clk);
    lookupAddr = a; lookupValid = 1'b1;
    @(negedge clk);
    lookupValid = 1'b0;
    check({req, " decision strobe (R2)"}, decisionValid, 1'b1);
    check(req, decisionAccept, exp);
    @(negedge clk);
    check({req, " strobe single cycle (R2)"}, decisionValid, 1'b0);
    check({req, " accept qualified (R12)"}, decisionAccept, 1'b0);
  endtask

  task automatic testReset();
    check("R1 valid after reset", decisionValid, 1'b0);
    check("R1 accept after reset", decisionAccept, 1'b0);
    runLookup("R1 empty tables reject", 48'h1234_5678_9ABC, 1'b0);
    runLookup("R10 all-ones with controls off", 48'hFFFF_FFFF_FFFF, 1'b0);
  endtask

  task automatic testUniPromisc();
    cfgUniPromisc = 1'b1;
    runLookup("R3 unicast promiscuous", 48'h1234_5678_9ABC, 1'b1);
    runLookup("R3 promiscuous zero addr", 48'h0, 1'b1);
    cfgUniPromisc = 1'b0;
    runLookup("R10 promiscuous cleared", 48'h1234_5678_9ABC, 1'b0);
  endtask

  task automatic testMultiPromisc();
    cfgMultiPromisc = 1'b1;
    runLookup("R4 group bit in byte 0", 48'h0000_0000_0001, 1'b1);
    runLookup("R4 bit 0 of byte 1 ignored", 48'h0000_0000_0100, 1'b0);
    cfgMultiPromisc = 1'b0;
    runLookup("R4 group bit without enable", 48'h0000_0000_0001, 1'b0);
  endtask

  task automatic testBroadcast();
    cfgBcastEn = 1'b1;
    runLookup("R5 broadcast accepted", 48'hFFFF_FFFF_FFFF, 1'b1);
    runLookup("R5 near-broadcast rejected", 48'hFFFF_FFFF_FFFE, 1'b0);
    cfgBcastEn = 1'b0;
    runLookup("R5 broadcast disabled", 48'hFFFF_FFFF_FFFF, 1'b0);
  endtask

  task automatic testExact();
    writeExact(4'd15, 32'h4433_2211, 32'h8000_6655);
    runLookup("R6 entry 15 match", 48'h6655_4433_2211, 1'b1);
    runLookup("R6 reversed byte order", 48'h1122_3344_5566, 1'b0);
    runLookup("R6 byte 0 differs", 48'h6655_4433_2210, 1'b0);
    runLookup("R6 byte 5 differs", 48'h6755_4433_2211, 1'b0);
    writeExact(4'd0, 32'hDDCC_BBAA, 32'h0000_FFEE);
    runLookup("R7 entry 0 without valid bit", 48'hFFEE_DDCC_BBAA, 1'b0);
    writeExact(4'd0, 32'hDDCC_BBAA, 32'h8000_FFEE);
    runLookup("R6 entry 0 match", 48'hFFEE_DDCC_BBAA, 1'b1);
    writeExact(4'd0, 32'hDDCC_BBAA, 32'h7FFF_FFEE);
    runLookup("R7 other high bits set, valid clear", 48'hFFEE_DDCC_BBAA, 1'b0);
  endtask

  // Address bytes 5,4 = AB,CD; indices: m0 ABC, m1 579, m2 AF3, m3 BCD.
  task automatic testHash();
    logic [47:0] a = 48'hABCD_0000_0002;
    logic [6:0]  wordSel [4] = '{7'd85, 7'd43, 7'd87, 7'd94};
    logic [4:0]  bitSel  [4] = '{5'd28, 5'd25, 5'd19, 5'd13};
    for (int m = 0; m < 4; m++) begin
      writeHash(wordSel[m], 32'h1 << bitSel[m]);
      cfgHashMode = 2'(m);
      runLookup($sformatf("R8 hash mode %0d hit", m), a, 1'b1);
      cfgHashMode = 2'((m + 1) % 4);
      runLookup($sformatf("R8 hash mode %0d word not set", (m + 1) % 4), a, 1'b0);
      writeHash(wordSel[m], 32'h0);
    end
    cfgHashMode = 2'd0;
    writeHash(7'd85, 32'h1 << 27);
    runLookup("R9 neighbouring bit only", a, 1'b0);
    writeHash(7'd84, 32'h1 << 28);
    runLookup("R9 neighbouring word only", a, 1'b0);
    writeHash(7'd85, ~(32'h1 << 28));
    runLookup("R9 all bits but the selected one", a, 1'b0);
    writeHash(7'd85, 32'h0);
    writeHash(7'd84, 32'h0);
  endtask

  task automatic testSameCycleWrite();
    writeExact(4'd3, 32'h0C0D_0E10, 32'h0000_0A0B);
    @(negedge clk);
    lookupAddr = 48'h0A0B_0C0D_0E10; lookupValid = 1'b1;
    exactWrEn = 1'b1; exactWrIdx = 4'd3; exactWrHigh = 1'b1;
    exactWrData = 32'h8000_0A0B;
    @(negedge clk);
    lookupValid = 1'b0; exactWrEn = 1'b0; exactWrHigh = 1'b0;
    check("R11 same-cycle validate unseen", decisionAccept, 1'b0);
    runLookup("R11 validate seen next lookup", 48'h0A0B_0C0D_0E10, 1'b1);
    @(negedge clk);
    lookupAddr = 48'h0A0B_0C0D_0E10; lookupValid = 1'b1;
    exactWrEn = 1'b1; exactWrIdx = 4'd3; exactWrHigh = 1'b1;
    exactWrData = 32'h0000_0A0B;
    @(negedge clk);
    lookupValid = 1'b0; exactWrEn = 1'b0; exactWrHigh = 1'b0;
    check("R11 same-cycle invalidate unseen", decisionAccept, 1'b1);
    runLookup("R11 invalidate seen next lookup", 48'h0A0B_0C0D_0E10, 1'b0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    lookupAddr = 48'h6655_4433_2211; lookupValid = 1'b1;
    @(negedge clk);
    check("R2 first of pair strobe", decisionValid, 1'b1);
    check("R2 first of pair accept", decisionAccept, 1'b1);
    lookupAddr = 48'h0000_0000_0002;
    @(negedge clk);
    lookupValid = 1'b0;
    check("R2 second of pair strobe", decisionValid, 1'b1);
    check("R10 second of pair reject", decisionAccept, 1'b0);
    @(negedge clk);
    check("R2 pair ends", decisionValid, 1'b0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testUniPromisc();
    testMultiPromisc();
    testBroadcast();
    testExact();
    testHash();
    testSameCycleWrite();
    testBackToBack();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected run completion");
    finishRun();
  end
endmodule